// File: doc/BRIEF.md
# Time Snapshot Register File With Change Flags

This block is a small register file between a bus interface and a set of live calendar counters. It holds a control byte, a read-only byte of per-field change flags, and eight snapshot registers for the time and date fields. Software reads and writes these bytes through a 4-bit-addressed byte port. The serial framing that feeds this port, and the counters themselves, are outside the block.

Two single-cycle command pulses drive the block. The capture command copies the live counter vector into the snapshot. At the same time it records, one flag per field, whether that field differs from the value taken at the previous capture. The load command presents the snapshot to the counters on a load vector with a one-cycle strobe, and clears the change flags. A lock bit in the control byte blocks the load command. The snapshot never follows the running clock on its own. It changes only on a capture command or a bus write.

Top module: `snap_regfile`

## Requirements
- R1: After reset the control byte, the change flags and all eight snapshot fields read zero, `load_stb_o` is low, and the three mode outputs are low.
- R2: Address 0 is the control byte. Only bit 0 (drives `freq_meas_o`), bit 2 (drives `test_accel_o`), bit 3 (drives `test_parallel_o`) and bit 4 (the lock) can be written. Bits 1, 5, 6 and 7 always read 0.
- R3: Addresses 2 through 9 hold snapshot fields 0 through 7: seconds, minutes, hours, day of month, month, year, weekday, week number. A bus write to one of these addresses stores the byte. Field i sits at bits [8i+7:8i] of `live_time_i` and of `load_time_o`.
- R4: One cycle after a capture pulse, every snapshot field equals the live vector sampled at that edge. Flag bit i (address 1) is 1 exactly when live field i differs from the value stored by the previous capture, which is zero after reset. Bus writes to the snapshot do not change this reference.
- R5: The flag byte at address 1 is read-only. Bus writes to address 1 leave it unchanged.
- R6: A load pulse while the lock is clear raises `load_stb_o` for exactly the next cycle. In that cycle `load_time_o` equals the snapshot as it was at the pulse, and the flag byte reads 0.
- R7: A load pulse while control bit 4 is set produces no strobe and leaves the flag byte unchanged.
- R8: The snapshot holds its value while `live_time_i` changes, unless a capture pulse or a bus write to addresses 2 through 9 occurs.
- R9: Reads of addresses 10 through 15 return 0. Writes to them change no register.
- R10: A capture pulse wins over a bus write to the snapshot in the same cycle. It also wins over a load pulse in the same cycle; that load is dropped and produces no strobe.
- R11: `bus_rdata_o` is combinational from `bus_addr_i`, so read data is valid in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 4 | Byte address for reads and writes |
| bus_wr_i | input | 1 | Write enable for the addressed byte |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| cmd_load_i | input | 1 | Pulse: copy snapshot to the counters |
| cmd_capture_i | input | 1 | Pulse: copy counters into the snapshot |
| live_time_i | input | 64 | Live counter fields, field i at [8i+7:8i] |
| load_time_o | output | 64 | Values to load into the counters |
| load_stb_o | output | 1 | One-cycle load strobe for the counters |
| freq_meas_o | output | 1 | Frequency-measurement mode enable |
| test_accel_o | output | 1 | Test mode 0: accelerated timekeeping |
| test_parallel_o | output | 1 | Test mode 1: parallel field increment |

## Verification
Most wrong state shows at the ports one clock edge after the command or write that caused it. A corrupted snapshot or flag register shows on the very next read of its address. A wrong lock decision shows as a strobe that is present or missing in the cycle after the load pulse. A corrupt capture reference is the one fault that stays hidden until the following capture, where it produces wrong flag bits. The directed scenarios therefore take captures in sequence, with snapshot writes between them, so that this reference gets exercised.

// File: rtl/snap_pkg.sv
package snap_pkg;
    localparam int FIELD_W_DEF    = 8;
    localparam int NUM_FIELDS_DEF = 8;
    localparam int ADDR_W_DEF     = 4;

    // address decode points
    localparam int CTRL_ADDR = 0;
    localparam int FLAG_ADDR = 1;
    localparam int SNAP_BASE = 2;

    // control byte bit positions
    localparam int BIT_FREQ     = 0;
    localparam int BIT_ACCEL    = 2;
    localparam int BIT_PARALLEL = 3;
    localparam int BIT_LOCK     = 4;
endpackage

// File: rtl/snap_ctrl_reg.sv
module snap_ctrl_reg
    import snap_pkg::*;
#(
    parameter int DATA_W = FIELD_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o
);
    // R2: only the defined mode and lock bits are storable
    localparam logic [DATA_W-1:0] WR_MASK = DATA_W'((1 << BIT_FREQ) | (1 << BIT_ACCEL)
                                                  | (1 << BIT_PARALLEL) | (1 << BIT_LOCK));

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            s_d.ctrl = wdata_i & WR_MASK;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o = s_q.ctrl;
endmodule

// File: rtl/snap_field_bank.sv
module snap_field_bank
    import snap_pkg::*;
#(
    parameter int FIELD_W    = FIELD_W_DEF,
    parameter int NUM_FIELDS = NUM_FIELDS_DEF
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic [NUM_FIELDS-1:0]                field_we_i,
    input  logic [FIELD_W-1:0]                   wdata_i,
    input  logic                                 capture_i,
    input  logic                                 load_i,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]   live_i,
    output logic [NUM_FIELDS-1:0][FIELD_W-1:0]   snap_o,
    output logic [NUM_FIELDS-1:0]                flags_o,
    output logic [NUM_FIELDS-1:0][FIELD_W-1:0]   load_time_o,
    output logic                                 load_stb_o
);
    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] tvec_t;

    typedef struct packed {
        tvec_t                 snap;      // software-visible snapshot
        tvec_t                 prev;      // reference from last capture only
        logic [NUM_FIELDS-1:0] flags;
        tvec_t                 load_time;
        logic                  load_stb;
    } state_t;

    state_t s_d, s_q;
    logic [NUM_FIELDS-1:0] diff;

    // R4: one comparator per field against the last captured value
    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
        assign diff[gi] = (live_i[gi] != s_q.prev[gi]);
    end

    always_comb begin
        s_d          = s_q;
        s_d.load_stb = 1'b0;
        if (capture_i) begin
            // R10: capture overrides bus writes and load in this cycle
            s_d.snap  = live_i;
            s_d.prev  = live_i;
            s_d.flags = diff;
        end else begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (field_we_i[i]) begin
                    s_d.snap[i] = wdata_i;
                end
            end
            if (load_i) begin
                // R6: present the pre-write snapshot and clear the flags
                s_d.load_stb  = 1'b1;
                s_d.load_time = s_q.snap;
                s_d.flags     = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign snap_o      = s_q.snap;
    assign flags_o     = s_q.flags;
    assign load_time_o = s_q.load_time;
    assign load_stb_o  = s_q.load_stb;
endmodule

// File: rtl/snap_read_mux.sv
module snap_read_mux
    import snap_pkg::*;
#(
    parameter int FIELD_W    = FIELD_W_DEF,
    parameter int NUM_FIELDS = NUM_FIELDS_DEF,
    parameter int ADDR_W     = ADDR_W_DEF
) (
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [FIELD_W-1:0]                 ctrl_i,
    input  logic [NUM_FIELDS-1:0]              flags_i,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] snap_i,
    output logic [FIELD_W-1:0]                 rdata_o
);
    // R9, R11: unmapped addresses fall through to zero
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(CTRL_ADDR)) begin
            rdata_o = ctrl_i;
        end
        if (addr_i == ADDR_W'(FLAG_ADDR)) begin
            rdata_o = FIELD_W'(flags_i);
        end
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr_i == ADDR_W'(SNAP_BASE + i)) begin
                rdata_o = snap_i[i];
            end
        end
    end
endmodule

// File: rtl/snap_regfile.sv
module snap_regfile
    import snap_pkg::*;
#(
    parameter int FIELD_W    = FIELD_W_DEF,
    parameter int NUM_FIELDS = NUM_FIELDS_DEF,
    parameter int ADDR_W     = ADDR_W_DEF
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic                          bus_wr_i,
    input  logic [FIELD_W-1:0]            bus_wdata_i,
    output logic [FIELD_W-1:0]            bus_rdata_o,
    input  logic                          cmd_load_i,
    input  logic                          cmd_capture_i,
    input  logic [NUM_FIELDS*FIELD_W-1:0] live_time_i,
    output logic [NUM_FIELDS*FIELD_W-1:0] load_time_o,
    output logic                          load_stb_o,
    output logic                          freq_meas_o,
    output logic                          test_accel_o,
    output logic                          test_parallel_o
);
    logic [FIELD_W-1:0]                 ctrl_q;
    logic [NUM_FIELDS-1:0]              flags_q;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] snap_q;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] live_v;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] load_v;
    logic [NUM_FIELDS-1:0]              field_we;
    logic                               ctrl_we;
    logic                               load_go;

    assign live_v = live_time_i;

    // R2: control byte at its fixed address; R5/R9: no other decode writes
    assign ctrl_we = bus_wr_i && (bus_addr_i == ADDR_W'(CTRL_ADDR));

    // R3: one write enable per snapshot field
    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_we
        assign field_we[gi] = bus_wr_i && (bus_addr_i == ADDR_W'(SNAP_BASE + gi));
    end

    // R7: lock gates the load; R10: capture drops a concurrent load
    assign load_go = cmd_load_i && !ctrl_q[BIT_LOCK] && !cmd_capture_i;

    snap_ctrl_reg #(
        .DATA_W (FIELD_W)
    ) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (ctrl_we),
        .wdata_i (bus_wdata_i),
        .ctrl_o  (ctrl_q)
    );

    snap_field_bank #(
        .FIELD_W    (FIELD_W),
        .NUM_FIELDS (NUM_FIELDS)
    ) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .field_we_i  (field_we),
        .wdata_i     (bus_wdata_i),
        .capture_i   (cmd_capture_i),
        .load_i      (load_go),
        .live_i      (live_v),
        .snap_o      (snap_q),
        .flags_o     (flags_q),
        .load_time_o (load_v),
        .load_stb_o  (load_stb_o)
    );

    snap_read_mux #(
        .FIELD_W    (FIELD_W),
        .NUM_FIELDS (NUM_FIELDS),
        .ADDR_W     (ADDR_W)
    ) u_rmux (
        .addr_i  (bus_addr_i),
        .ctrl_i  (ctrl_q),
        .flags_i (flags_q),
        .snap_i  (snap_q),
        .rdata_o (bus_rdata_o)
    );

    assign load_time_o     = load_v;
    assign freq_meas_o     = ctrl_q[BIT_FREQ];
    assign test_accel_o    = ctrl_q[BIT_ACCEL];
    assign test_parallel_o = ctrl_q[BIT_PARALLEL];
endmodule

// File: rtl/snap_regfile_chk.sv
module snap_regfile_chk
    import snap_pkg::*;
#(
    parameter int FIELD_W    = FIELD_W_DEF,
    parameter int NUM_FIELDS = NUM_FIELDS_DEF,
    parameter int ADDR_W     = ADDR_W_DEF
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic [ADDR_W-1:0]             bus_addr_i,
    input logic                          bus_wr_i,
    input logic [FIELD_W-1:0]            bus_rdata_o,
    input logic                          cmd_load_i,
    input logic                          cmd_capture_i,
    input logic [NUM_FIELDS*FIELD_W-1:0] live_time_i,
    input logic [NUM_FIELDS*FIELD_W-1:0] load_time_o,
    input logic                          load_stb_o,
    input logic [FIELD_W-1:0]            ctrl_q,
    input logic [NUM_FIELDS-1:0]         flags_q,
    input logic [NUM_FIELDS*FIELD_W-1:0] snap_q
);
    logic snap_addr;
    assign snap_addr = (bus_addr_i >= ADDR_W'(SNAP_BASE))
                    && (int'(bus_addr_i) < SNAP_BASE + NUM_FIELDS);

    assert_load_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_load_i && !cmd_capture_i && !ctrl_q[BIT_LOCK])
        |=> (load_stb_o && load_time_o == $past(snap_q) && flags_q == '0));

    assert_strobe_needs_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_stb_o |-> $past(cmd_load_i));

    assert_lock_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_load_i && !cmd_capture_i && ctrl_q[BIT_LOCK])
        |=> (!load_stb_o && $stable(flags_q)));

    assert_capture_takes_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_capture_i |=> (snap_q == $past(live_time_i)));

    assert_capture_drops_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_capture_i |=> !load_stb_o);

    assert_snap_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cmd_capture_i && !(bus_wr_i && snap_addr)) |=> $stable(snap_q));

    assert_flags_readonly_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cmd_capture_i && !cmd_load_i) |=> $stable(flags_q));

    assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(bus_addr_i) >= SNAP_BASE + NUM_FIELDS) |-> (bus_rdata_o == '0));

    assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == ADDR_W'(CTRL_ADDR))
        |-> (bus_rdata_o[1] == 1'b0 && bus_rdata_o[FIELD_W-1:5] == '0));
endmodule

bind snap_regfile snap_regfile_chk #(
    .FIELD_W    (FIELD_W),
    .NUM_FIELDS (NUM_FIELDS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bus_addr_i    (bus_addr_i),
    .bus_wr_i      (bus_wr_i),
    .bus_rdata_o   (bus_rdata_o),
    .cmd_load_i    (cmd_load_i),
    .cmd_capture_i (cmd_capture_i),
    .live_time_i   (live_time_i),
    .load_time_o   (load_time_o),
    .load_stb_o    (load_stb_o),
    .ctrl_q        (ctrl_q),
    .flags_q       (flags_q),
    .snap_q        (snap_q)
);

// File: tb/snap_regfile_bench.sv
`timescale 1ns/1ps
module snap_regfile_bench;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      addr = '0;
    logic            wr = 1'b0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic            load = 1'b0;
    logic            cap = 1'b0;
    logic [7:0][7:0] live = '0;
    logic [63:0]     load_time;
    logic            load_stb;
    logic            freq, accel, par;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    snap_regfile u_snap_regfile (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .bus_addr_i      (addr),
        .bus_wr_i        (wr),
        .bus_wdata_i     (wdata),
        .bus_rdata_o     (rdata),
        .cmd_load_i      (load),
        .cmd_capture_i   (cap),
        .live_time_i     (live),
        .load_time_o     (load_time),
        .load_stb_o      (load_stb),
        .freq_meas_o     (freq),
        .test_accel_o    (accel),
        .test_parallel_o (par)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic read_check(input logic [3:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        check(tag, {56'd0, rdata}, {56'd0, exp});
    endtask

    task automatic capture();
        @(negedge clk); cap = 1'b1;
        @(negedge clk); cap = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 10; a++) read_check(4'(a), 8'h00, "R1 reset read");
        check("R1 reset strobe", {63'd0, load_stb}, 64'd0);
        check("R1 reset modes", {61'd0, freq, accel, par}, 64'd0);
    endtask

    task automatic t_ctrl();
        bus_write(4'd0, 8'hFF);
        read_check(4'd0, 8'h1D, "R2 ctrl reserved bits");
        check("R2 all modes on", {61'd0, freq, accel, par}, 64'd7);
        bus_write(4'd0, 8'h04);
        read_check(4'd0, 8'h04, "R2 ctrl readback");
        check("R2 accel only", {61'd0, freq, accel, par}, 64'd2);
        bus_write(4'd0, 8'h00);
    endtask

    task automatic t_snap_rw();
        for (int i = 0; i < 8; i++) bus_write(4'(2 + i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 8; i++) read_check(4'(2 + i), 8'(8'h11 * (i + 1)), "R3 field readback");
        read_check(4'd1, 8'h00, "R3 writes leave flags");
    endtask

    task automatic t_unmapped();
        for (int a = 10; a < 16; a++) bus_write(4'(a), 8'hA5);
        for (int a = 10; a < 16; a++) read_check(4'(a), 8'h00, "R9 unmapped read");
        read_check(4'd2, 8'h11, "R9 seconds untouched");
        read_check(4'd0, 8'h00, "R9 ctrl untouched");
    endtask

    task automatic t_capture();
        live = {8'h03, 8'h24, 8'h07, 8'h15, 8'h00, 8'h12, 8'h30, 8'h45};
        // capture together with a bus write to seconds: capture wins (R10)
        @(negedge clk);
        cap = 1'b1; wr = 1'b1; addr = 4'd2; wdata = 8'h99;
        @(negedge clk);
        cap = 1'b0; wr = 1'b0;
        read_check(4'd2, 8'h45, "R10 capture beats write");
        read_check(4'd1, 8'hF7, "R4 first capture flags");
        for (int i = 0; i < 8; i++) read_check(4'(2 + i), live[i], "R4 snapshot equals live");
        // live moves without a capture
        live[0] = 8'h46; live[1] = 8'h31;
        repeat (3) @(negedge clk);
        read_check(4'd2, 8'h45, "R8 seconds held");
        read_check(4'd3, 8'h30, "R8 minutes held");
        capture();
        read_check(4'd1, 8'h03, "R4 second capture flags");
        read_check(4'd3, 8'h31, "R4 minutes updated");
        // a bus write does not move the comparison reference
        bus_write(4'd4, 8'h77);
        capture();
        read_check(4'd1, 8'h00, "R4 reference ignores bus write");
        read_check(4'd4, 8'h12, "R4 hours restored by capture");
    endtask

    task automatic t_flags_ro();
        live[0] = 8'h47;
        capture();
        read_check(4'd1, 8'h01, "R5 flags before write");
        bus_write(4'd1, 8'hFE);
        read_check(4'd1, 8'h01, "R5 flags after write");
    endtask

    task automatic t_load();
        logic [7:0][7:0] expv;
        for (int i = 0; i < 8; i++) begin
            expv[i] = 8'(i + 1);
            bus_write(4'(2 + i), expv[i]);
        end
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        check("R6 strobe high", {63'd0, load_stb}, 64'd1);
        check("R6 load vector", load_time, expv);
        read_check(4'd1, 8'h00, "R6 flags cleared");
        @(negedge clk);
        check("R6 strobe one cycle", {63'd0, load_stb}, 64'd0);
    endtask

    task automatic t_lock();
        bus_write(4'd0, 8'h10);
        live[1] = 8'h32;
        capture();
        read_check(4'd1, 8'h02, "R7 flags before locked load");
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        check("R7 no strobe when locked", {63'd0, load_stb}, 64'd0);
        read_check(4'd1, 8'h02, "R7 flags kept when locked");
        bus_write(4'd0, 8'h00);
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        check("R7 strobe after unlock", {63'd0, load_stb}, 64'd1);
    endtask

    task automatic t_cap_load();
        @(negedge clk); load = 1'b1; cap = 1'b1;
        @(negedge clk); load = 1'b0; cap = 1'b0;
        check("R10 load dropped on capture", {63'd0, load_stb}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_snap_rw();
        t_unmapped();
        t_capture();
        t_flags_ro();
        t_load();
        t_lock();
        t_cap_load();   // R11 is covered by every same-cycle read_check
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule